// File: doc/BRIEF.md
# Interrupt Pin Controller

This block merges a bank of sticky interrupt requests into a single external interrupt line. Internal event logic raises a request bit with a one-cycle set pulse. Software clears the bit by writing a one to its position. A matching bank of enable bits decides which requests count, and the line reflects the registered OR of the enabled pending requests.

Three configuration bits shape the line. A global enable holds the line inactive when it is zero. A mode bit chooses between level signalling and pulse signalling. A polarity bit applies only in pulse mode. In level mode the line is driven low while anything enabled is pending. In pulse mode each indication is a fixed-width pulse timed by an external microsecond tick. A fresh pulse is issued when software clears one request while another enabled request is still waiting, so an edge-sensitive receiver never misses the remaining work.

A bus reset input clears the enable bank, except for a parameterised set of enables that survive it.

Top module: `irq_pin_ctrl`

## Requirements
- R1: While the global enable is 0, the line is inactive whatever is pending. Inactive means high in level mode, and the inverse of the polarity bit in pulse mode.
- R2: In level mode (mode bit 0) with the global enable at 1, the line is low while any enabled request is pending and high otherwise. The polarity bit has no effect in this mode.
- R3: In pulse mode (mode bit 1), a rise of the pending term produces one pulse lasting PULSE_TICKS microsecond ticks. The pulse is at level 1 when the polarity bit is 1 and at level 0 when it is 0, and the line rests at the opposite level.
- R4: In pulse mode, a write-1-to-clear that removes an enabled pending request while another enabled request remains pending produces a new pulse. If nothing changes, no further pulse follows.
- R5: A trigger that arrives during a pulse does not lengthen it. The trigger is held, and a second pulse follows after an inactive gap of at least one tick boundary.
- R6: A bus reset pulse clears every enable bit except those set in KEEP_MASK, which keep their values. The default KEEP_MASK is bits 6 and 7.
- R7: Request bit i is set by set_req[i] and cleared by clr_wr with clr_mask[i]=1. Zero mask bits leave their requests alone. When set and clear act on the same bit in the same cycle, the set wins.
- R8: The pending term is the OR over all bits of request AND enable. It is registered, so the line changes two clock edges after a set pulse. A request whose enable is 0 never drives the line.
- R9: After reset all requests, enables and configuration bits are 0, and the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | One-cycle bus reset event; clears non-kept enables |
| set_req | input | N_SRC | Request set pulses from event logic |
| clr_wr | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | N_SRC | Bits to clear when clr_wr is 1 |
| en_wr | input | 1 | Enable bank write strobe |
| en_data | input | N_SRC | New enable bank value |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_glob_en | input | 1 | Global line enable value |
| cfg_pulse_mode | input | 1 | 0 = level mode, 1 = pulse mode |
| cfg_pos_pol | input | 1 | Pulse polarity, 1 = active high |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| req_q | output | N_SRC | Request bank state |
| en_q | output | N_SRC | Enable bank state |
| irq_pin | output | 1 | Interrupt line |

## Verification
The bench uses N_SRC=8, PULSE_TICKS=4 and a tick every five clocks, so one pulse lasts about twenty cycles. Width, gap and retrigger behaviour can therefore be observed many times within a short run. The default KEEP_MASK is kept, so the bus reset check sees both surviving and cleared enables in one byte. These small values also bring the held-trigger gap and the no-extension rule within reach of cycle-counted measurement.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'd0,
        PIN_PULSE = 2'd1,
        PIN_GAP   = 2'd2
    } pin_state_e;

    typedef struct packed {
        logic glob_en;
        logic pulse_mode;
        logic pos_pol;
    } irq_cfg_t;

endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_req,
    input  logic             clr_wr,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] req_q
);
    logic [N_SRC-1:0] req_d;

    always_comb begin
        req_d = req_q;
        if (clr_wr) begin
            req_d = req_d & ~clr_mask;
        end
        req_d = req_d | set_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
    parameter int               N_SRC     = 8,
    parameter logic [N_SRC-1:0] KEEP_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] en_data,
    output logic [N_SRC-1:0] en_q
);
    logic [N_SRC-1:0] en_d;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (KEEP_MASK[i]) begin : g_keep
            always_comb begin
                en_d[i] = en_q[i];
                if (!bus_reset && en_wr) begin
                    en_d[i] = en_data[i];
                end
            end
        end else begin : g_clear
            always_comb begin
                en_d[i] = en_q[i];
                if (bus_reset) begin
                    en_d[i] = 1'b0;
                end else if (en_wr) begin
                    en_d[i] = en_data[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer
    import irq_pin_pkg::*;
#(
    parameter int PULSE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic trig,
    input  logic us_tick,
    output logic active
);
    localparam int CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

    typedef struct packed {
        pin_state_e    st;
        logic [CW-1:0] cnt;
        logic          armed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d.st    = PIN_IDLE;
            tmr_d.cnt   = '0;
            tmr_d.armed = 1'b0;
        end else begin
            unique case (tmr_q.st)
                PIN_IDLE: begin
                    if (tmr_q.armed || trig) begin
                        tmr_d.st    = PIN_PULSE;
                        tmr_d.cnt   = '0;
                        tmr_d.armed = 1'b0;
                    end
                end
                PIN_PULSE: begin
                    tmr_d.armed = tmr_q.armed | trig;
                    if (us_tick) begin
                        if (tmr_q.cnt == LAST) begin
                            tmr_d.st = PIN_GAP;
                        end else begin
                            tmr_d.cnt = tmr_q.cnt + 1'b1;
                        end
                    end
                end
                PIN_GAP: begin
                    tmr_d.armed = tmr_q.armed | trig;
                    if (us_tick) begin
                        tmr_d.st = PIN_IDLE;
                    end
                end
                default: tmr_d.st = PIN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{st: PIN_IDLE, cnt: '0, armed: 1'b0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active = (tmr_q.st == PIN_PULSE);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int               N_SRC       = 8,
    parameter int               PULSE_TICKS = 20,
    parameter logic [N_SRC-1:0] KEEP_MASK   = N_SRC'(8'hC0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic [N_SRC-1:0] set_req,
    input  logic             clr_wr,
    input  logic [N_SRC-1:0] clr_mask,
    input  logic             en_wr,
    input  logic [N_SRC-1:0] en_data,
    input  logic             cfg_wr,
    input  logic             cfg_glob_en,
    input  logic             cfg_pulse_mode,
    input  logic             cfg_pos_pol,
    input  logic             us_tick,
    output logic [N_SRC-1:0] req_q,
    output logic [N_SRC-1:0] en_q,
    output logic             irq_pin
);
    typedef struct packed {
        irq_cfg_t cfg;
        logic     pend;
        logic     hit;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic pend_now;
    logic trig;
    logic active;
    logic run;

    irq_req_bank #(.N_SRC(N_SRC)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .req_q    (req_q)
    );

    irq_en_bank #(.N_SRC(N_SRC), .KEEP_MASK(KEEP_MASK)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .en_wr     (en_wr),
        .en_data   (en_data),
        .en_q      (en_q)
    );

    assign pend_now = |(req_q & en_q);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.pend = pend_now;
        ctl_d.hit  = clr_wr && (|(clr_mask & req_q & en_q));
        if (cfg_wr) begin
            ctl_d.cfg.glob_en    = cfg_glob_en;
            ctl_d.cfg.pulse_mode = cfg_pulse_mode;
            ctl_d.cfg.pos_pol    = cfg_pos_pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign run  = ctl_q.cfg.glob_en && ctl_q.cfg.pulse_mode;
    assign trig = (pend_now && !ctl_q.pend) || (ctl_q.hit && pend_now);

    irq_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .trig    (trig),
        .us_tick (us_tick),
        .active  (active)
    );

    always_comb begin
        if (ctl_q.cfg.pulse_mode) begin
            irq_pin = (ctl_q.cfg.glob_en && active) ? ctl_q.cfg.pos_pol : ~ctl_q.cfg.pos_pol;
        end else begin
            irq_pin = !(ctl_q.cfg.glob_en && ctl_q.pend);
        end
    end
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
    parameter int               N_SRC     = 8,
    parameter logic [N_SRC-1:0] KEEP_MASK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             en_wr,
    input logic [N_SRC-1:0] set_req,
    input logic             clr_wr,
    input logic [N_SRC-1:0] clr_mask,
    input logic [N_SRC-1:0] req_q,
    input logic [N_SRC-1:0] en_q,
    input logic             glob_en,
    input logic             pulse_mode,
    input logic             pos_pol,
    input logic             irq_pin
);
    assert_line_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (irq_pin == (pulse_mode ? ~pos_pol : 1'b1)));

    assert_level_low_when_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && !pulse_mode && $past(glob_en && !pulse_mode) && $past(|(req_q & en_q)))
        |-> !irq_pin);

    assert_set_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_req) |=> ((req_q & $past(set_req)) == $past(set_req)));

    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((req_q & $past(clr_mask & ~set_req)) == '0));

    assert_bus_reset_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (((en_q & ~KEEP_MASK) == '0) &&
                       ((en_q & KEEP_MASK) == ($past(en_q) & KEEP_MASK))));
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.N_SRC(N_SRC), .KEEP_MASK(KEEP_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .en_wr      (en_wr),
    .set_req    (set_req),
    .clr_wr     (clr_wr),
    .clr_mask   (clr_mask),
    .req_q      (req_q),
    .en_q       (en_q),
    .glob_en    (ctl_q.cfg.glob_en),
    .pulse_mode (ctl_q.cfg.pulse_mode),
    .pos_pol    (ctl_q.cfg.pos_pol),
    .irq_pin    (irq_pin)
);

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;
    localparam int N = 8;
    localparam int PT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_reset = 1'b0;
    logic [N-1:0] set_req = '0;
    logic         clr_wr = 1'b0;
    logic [N-1:0] clr_mask = '0;
    logic         en_wr = 1'b0;
    logic [N-1:0] en_data = '0;
    logic         cfg_wr = 1'b0;
    logic         cfg_glob_en = 1'b0;
    logic         cfg_pulse_mode = 1'b0;
    logic         cfg_pos_pol = 1'b0;
    logic         us_tick = 1'b0;
    logic [N-1:0] req_q, en_q;
    logic         irq_pin;

    int n_tests = 0;
    int n_fail = 0;

    typedef struct {
        int    kind;
        int    val;
        string tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    irq_pin_ctrl #(.N_SRC(N), .PULSE_TICKS(PT)) u_irq_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .set_req(set_req),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .en_wr(en_wr), .en_data(en_data),
        .cfg_wr(cfg_wr), .cfg_glob_en(cfg_glob_en), .cfg_pulse_mode(cfg_pulse_mode),
        .cfg_pos_pol(cfg_pos_pol), .us_tick(us_tick), .req_q(req_q), .en_q(en_q),
        .irq_pin(irq_pin)
    );

    // tick every 5 clocks
    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            us_tick = (c == 4);
            c = (c == 4) ? 0 : c + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compares each queued item after the following edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            item_t it;
            int act;
            it = exp_q.pop_front();
            act = (it.kind == 0) ? int'(irq_pin) : (it.kind == 1) ? int'(req_q) : int'(en_q);
            chk(act == it.val, it.tag, act, it.val);
        end
    end

    task automatic expect_item(input int kind, input int val, input string tag);
        @(negedge clk);
        exp_q.push_back('{kind, val, tag});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input bit g, input bit p, input bit pol);
        @(negedge clk);
        cfg_wr = 1; cfg_glob_en = g; cfg_pulse_mode = p; cfg_pos_pol = pol;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic write_en(input logic [N-1:0] v);
        @(negedge clk);
        en_wr = 1; en_data = v;
        @(negedge clk);
        en_wr = 0;
    endtask

    task automatic pulse_set(input logic [N-1:0] v);
        @(negedge clk);
        set_req = v;
        @(negedge clk);
        set_req = '0;
    endtask

    task automatic pulse_clr(input logic [N-1:0] v);
        @(negedge clk);
        clr_wr = 1; clr_mask = v;
        @(negedge clk);
        clr_wr = 0; clr_mask = '0;
    endtask

    task automatic wait_pin(input logic v, input int maxc, output bit ok);
        ok = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (irq_pin == v) begin ok = 1; break; end
        end
    endtask

    task automatic count_while(input logic v, input int maxc, output int n);
        n = 0;
        while (irq_pin == v && n < maxc) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        bit ok;
        int w, g;
        idle(3);
        rst_n = 1;
        idle(2);
        // R9 reset state
        expect_item(0, 1, "R9 pin after reset");
        expect_item(1, 0, "R9 req after reset");
        expect_item(2, 0, "R9 en after reset");

        // R7 set and clear
        pulse_set(8'h0F);
        expect_item(1, 8'h0F, "R7 set");
        pulse_clr(8'h05);
        expect_item(1, 8'h0A, "R7 w1c");
        @(negedge clk);
        set_req = 8'h02; clr_wr = 1; clr_mask = 8'h02;
        @(negedge clk);
        set_req = '0; clr_wr = 0; clr_mask = '0;
        expect_item(1, 8'h0A, "R7 set wins");

        // R8 disabled requests do not drive, R1 global off
        write_cfg(1, 0, 0);
        idle(3);
        expect_item(0, 1, "R8 disabled request ignored");
        write_en(8'h02);
        idle(3);
        expect_item(0, 0, "R2 level low while pending");
        write_cfg(1, 0, 1);
        idle(2);
        expect_item(0, 0, "R2 polarity ignored in level");
        write_cfg(0, 0, 0);
        idle(2);
        expect_item(0, 1, "R1 level off");
        write_cfg(0, 1, 1);
        idle(2);
        expect_item(0, 0, "R1 pulse off");
        pulse_clr('1);
        write_cfg(1, 0, 0);
        idle(3);
        expect_item(0, 1, "R2 high with nothing pending");

        // R8 two-edge latency in level mode
        @(negedge clk);
        set_req = 8'h02;
        @(negedge clk);
        set_req = '0;
        chk(irq_pin == 1'b1, "R8 not yet after one edge", irq_pin, 1);
        @(negedge clk);
        chk(irq_pin == 1'b0, "R8 after two edges", irq_pin, 0);
        pulse_clr('1);

        // R6 bus reset
        write_en(8'hFF);
        @(negedge clk);
        bus_reset = 1;
        @(negedge clk);
        bus_reset = 0;
        expect_item(2, 8'hC0, "R6 kept enables");

        // pulse mode, active high
        write_en(8'h03);
        write_cfg(1, 1, 1);
        idle(3);
        expect_item(0, 0, "R3 rest level low");
        pulse_set(8'h01);
        wait_pin(1, 30, ok);
        chk(ok, "R3 pulse appears", ok, 1);
        count_while(1, 60, w);
        chk(w >= 15 && w <= 21, "R3 pulse width", w, 20);
        idle(10);
        pulse_set(8'h02);
        wait_pin(1, 30, ok);
        chk(!ok, "R4 no pulse while pending unchanged", ok, 0);
        pulse_clr(8'h01);
        wait_pin(1, 30, ok);
        chk(ok, "R4 retrigger on clear", ok, 1);
        count_while(1, 60, w);
        chk(w >= 15 && w <= 21, "R4 retrigger width", w, 20);
        pulse_clr(8'h02);
        wait_pin(1, 30, ok);
        chk(!ok, "R4 last clear gives no pulse", ok, 0);

        // R5 trigger during pulse
        pulse_set(8'h01);
        wait_pin(1, 30, ok);
        fork
            count_while(1, 60, w);
            begin
                idle(4);
                clr_wr = 1; clr_mask = 8'h01;
                @(negedge clk);
                clr_wr = 0; clr_mask = '0;
                idle(2);
                set_req = 8'h02;
                @(negedge clk);
                set_req = '0;
            end
        join
        chk(w >= 15 && w <= 21, "R5 pulse not extended", w, 20);
        count_while(0, 60, g);
        chk(g >= 1 && g <= 10, "R5 gap then second pulse", g, 5);
        pulse_clr('1);
        idle(30);

        // R3 active-low polarity
        write_cfg(1, 1, 0);
        idle(2);
        expect_item(0, 1, "R3 rest level high");
        pulse_set(8'h01);
        wait_pin(0, 30, ok);
        chk(ok, "R3 low pulse", ok, 1);
        count_while(0, 60, w);
        chk(w >= 15 && w <= 21, "R3 low pulse width", w, 20);

        idle(4);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule